// File: doc/BRIEF.md
# Register-Bank CRC-8 Integrity Controller

This block protects two fixed, contiguous windows of a byte-wide register file with an 8-bit cyclic check. The non-volatile window holds configuration bytes that are loaded or committed as a group. The threshold window holds detection thresholds that software may rewrite at any time. Each window is followed directly by one byte that holds its check value.

When a window needs checking, the controller walks its bytes in ascending address order through the register file's synchronous read port. It folds each byte into a CRC-8 accumulator, eight bits per clock. It then reads the stored check byte, writes the fresh value over it, and records the outcome in a per-window error flag.

The non-volatile window is checked after a commit request, after a reload request, and once on its own after reset. A reload compares the old stored byte against the fresh result; a commit does not. The threshold window is checked whenever the host writes one of its data bytes. Host writes pass through the controller on their way to the register file. A write is held off only while it would disturb the window being scanned, or while the controller itself owns the write port.

Top module: `crcGuardTop`

## Requirements
- R1: The check value uses generator x^8+x^2+x+1 (0x07) and seed 0xFF. Bytes are taken most significant bit first, with no reflection and no final inversion. They are fed in ascending address order, so the lowest address comes first in the message.
- R2: The non-volatile window spans data addresses 0x00 to 0x2A, and its check byte is written to 0x2B. The threshold window spans data addresses 0x5F to 0x7E, and its check byte is written to 0x7F.
- R3: While reset is low, busy is 0, the non-volatile error flag is 0 and the threshold error flag is 1. On the first clock edge after reset is released, a reload-type check of the non-volatile window begins.
- R4: A request sampled on edge k, with the controller idle, makes busy go high on edge k+1. For a window with N data bytes, busy then stays high for N+2 cycles: 45 cycles for the non-volatile window and 34 for the threshold window.
- R5: While scanning, the read enable is high for N+1 consecutive cycles. The read address steps by one each cycle, from the window's first data address to its check-byte address. Read data is taken one cycle after its address.
- R6: A reload-type check sets the non-volatile error flag if the stored check byte differs from the computed value, and clears it if they are equal. A commit-type check always clears it.
- R7: An accepted host write to any address from 0x5F to 0x7E requests a threshold check. A completed threshold check clears the threshold error flag. Writes to 0x7F or outside the threshold window do not request a check.
- R8: A request that arrives while busy, or while another request is waiting, is held and served after the current scan. Repeated requests for the same window merge into one scan. When both windows are waiting, the non-volatile window is served first. For the non-volatile window, the latest of commit or reload decides the kind of check; if both arrive in the same cycle, reload wins.
- R9: A host write is refused (accept low, nothing written) during the write-back cycle. It is also refused during a scan if its address lies within the scanned window, including that window's check byte. Any other host write is accepted and reaches the write port in the same cycle.
- R10: The error flags change only on the clock edge that ends a write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progReq | input | 1 | Commit request for the non-volatile window (check without compare) |
| reloadReq | input | 1 | Reload request for the non-volatile window (check with compare) |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 7 | Host write address |
| hostWrData | input | 8 | Host write data |
| hostWrAccept | output | 1 | Host write taken this cycle |
| rfRdEn | output | 1 | Register-file read enable |
| rfRdAddr | output | 7 | Register-file read address |
| rfRdData | input | 8 | Register-file read data, valid one cycle after the address |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrAddr | output | 7 | Register-file write address |
| rfWrData | output | 8 | Register-file write data |
| busy | output | 1 | A window scan or write-back is in progress |
| nvCrcErr | output | 1 | Non-volatile window check failed |
| thrCrcErr | output | 1 | Threshold window check is failed or not yet done |

## Verification
A request sampled on one edge raises busy one edge later. The read addresses then follow on consecutive cycles, and the check byte and both flags land on the edge that closes the N+2-cycle busy period. A host write's acceptance is combinational in the cycle it is presented. The bench keeps a behavioural model that advances on each rising edge from the same inputs. It compares busy, flags, acceptance, read address and write-back byte at mid-cycle against that model, so every expectation is taken in the exact cycle the requirements fix. At the end it compares the whole register file with the model's copy.

// File: rtl/crcGuardPkg.sv
package crcGuardPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_WB
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic seed;       // load the seed into the accumulator
    logic issueData;  // a data byte read is issued this cycle
  } dpCtrl_t;

endpackage

// File: rtl/crcByteStep.sv
module crcByteStep #(
  parameter int          CRC_W = 8,
  parameter logic [7:0]  POLY  = 8'h07
) (
  input  logic [CRC_W-1:0] crcIn,
  input  logic [CRC_W-1:0] dataIn,
  output logic [CRC_W-1:0] crcOut
);

  logic [CRC_W-1:0] stage [0:CRC_W];

  assign stage[0] = crcIn ^ dataIn;

  for (genvar b = 0; b < CRC_W; b++) begin : g_bit
    assign stage[b+1] = stage[b][CRC_W-1] ? ((stage[b] << 1) ^ POLY[CRC_W-1:0])
                                          : (stage[b] << 1);
  end

  assign crcOut = stage[CRC_W];

endmodule

// File: rtl/crcGuardDatapath.sv
module crcGuardDatapath
  import crcGuardPkg::*;
#(
  parameter logic [7:0] POLY = 8'h07,
  parameter logic [7:0] SEED = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctrl,
  input  logic [7:0] rdData,
  output logic [7:0] crcQ,
  output logic       mismatch
);

  logic       feedQ;
  logic [7:0] crcNext;

  crcByteStep #(.CRC_W(8), .POLY(POLY)) u_step (
    .crcIn  (crcQ),
    .dataIn (rdData),
    .crcOut (crcNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      feedQ <= 1'b0;
      crcQ  <= SEED;
    end else begin
      feedQ <= ctrl.issueData;
      if (ctrl.seed)
        crcQ <= SEED;
      else if (feedQ)
        crcQ <= crcNext;
    end
  end

  // byte returned by the read port compared with the accumulator
  assign mismatch = (rdData != crcQ);

  // r1: accumulator moves only while returned data is being folded in
  a_r1_acc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!feedQ && !ctrl.seed) |=> $stable(crcQ));

endmodule

// File: rtl/crcGuardControl.sv
module crcGuardControl
  import crcGuardPkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned NV_BASE  = 0,
  parameter int unsigned NV_LEN   = 43,
  parameter int unsigned THR_BASE = 95,
  parameter int unsigned THR_LEN  = 32,
  parameter logic [7:0]  SEED     = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progReq,
  input  logic              reloadReq,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  input  logic [7:0]        crcQ,
  input  logic              mismatch,
  output dpCtrl_t           ctrl,
  output logic              rfRdEn,
  output logic [ADDR_W-1:0] rfRdAddr,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [7:0]        rfWrData,
  output logic              hostWrAccept,
  output logic              busy,
  output logic              nvErr,
  output logic              thrErr
);

  localparam int unsigned MAX_LEN = (NV_LEN > THR_LEN) ? NV_LEN : THR_LEN;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [ADDR_W-1:0] NV_B   = ADDR_W'(NV_BASE);
  localparam logic [ADDR_W-1:0] THR_B  = ADDR_W'(THR_BASE);
  localparam logic [ADDR_W-1:0] THR_CK = ADDR_W'(THR_BASE + THR_LEN);

  scanState_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              isThr;
  logic              chkQ;
  logic              nvPend, nvChkPend, thrPend;
  logic              startNv, startThr, thrTrig, blocked, inCur, wbCycle;
  logic [ADDR_W-1:0] curBase, curCk;
  logic [CNT_W-1:0]  curLen;

  // window currently owned by the scanner
  assign curBase = isThr ? THR_B : NV_B;
  assign curLen  = isThr ? CNT_W'(THR_LEN) : CNT_W'(NV_LEN);
  assign curCk   = curBase + ADDR_W'(curLen);
  assign inCur   = (hostAddr >= curBase) && (hostAddr <= curCk);
  assign wbCycle = (state == ST_WB);

  // host write arbitration
  assign blocked      = wbCycle || ((state == ST_SCAN) && inCur);
  assign hostWrAccept = hostWrEn && !blocked;
  assign thrTrig      = hostWrAccept && (hostAddr >= THR_B) && (hostAddr < THR_CK);

  // request selection: non-volatile window first
  assign startNv  = (state == ST_IDLE) && nvPend;
  assign startThr = (state == ST_IDLE) && !nvPend && thrPend;

  assign ctrl.seed      = startNv || startThr;
  assign ctrl.issueData = (state == ST_SCAN) && (cnt != curLen);

  assign rfRdEn   = (state == ST_SCAN);
  assign rfRdAddr = curBase + ADDR_W'(cnt);
  assign rfWrEn   = hostWrAccept || wbCycle;
  assign rfWrAddr = wbCycle ? curCk : hostAddr;
  assign rfWrData = wbCycle ? crcQ : hostWrData;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      isThr     <= 1'b0;
      chkQ      <= 1'b0;
      nvPend    <= 1'b1;   // power-up reload
      nvChkPend <= 1'b1;
      thrPend   <= 1'b0;
      nvErr     <= 1'b0;
      thrErr    <= 1'b1;   // thresholds unchecked after reset
    end else begin
      nvPend    <= (nvPend && !startNv) || progReq || reloadReq;
      nvChkPend <= reloadReq ? 1'b1 : (progReq ? 1'b0 : nvChkPend);
      thrPend   <= (thrPend && !startThr) || thrTrig;
      unique case (state)
        ST_IDLE: begin
          if (startNv || startThr) begin
            state <= ST_SCAN;
            cnt   <= '0;
            isThr <= startThr;
            chkQ  <= startNv && nvChkPend;
          end
        end
        ST_SCAN: begin
          if (cnt == curLen) state <= ST_WB;
          else               cnt   <= cnt + 1'b1;
        end
        ST_WB: begin
          state <= ST_IDLE;
          if (isThr) thrErr <= 1'b0;
          else       nvErr  <= chkQ && mismatch;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // r4: a fresh scan always starts from the seed
  a_r4_seed_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (crcQ == SEED));

  // r5: read addresses advance by one on back-to-back reads
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (rfRdEn && $past(rfRdEn)) |-> (rfRdAddr == ADDR_W'($past(rfRdAddr) + 1'b1)));

  // r9: a controller-owned write follows the read burst and never overlaps it
  a_r9_wb_after_reads: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && !hostWrAccept) |-> ($past(rfRdEn) && !rfRdEn));

  // r10: flags hold outside the write-back cycle
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wbCycle |=> $stable({nvErr, thrErr}));

endmodule

// File: rtl/crcGuardTop.sv
module crcGuardTop
  import crcGuardPkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned NV_BASE  = 0,
  parameter int unsigned NV_LEN   = 43,
  parameter int unsigned THR_BASE = 95,
  parameter int unsigned THR_LEN  = 32,
  parameter logic [7:0]  POLY     = 8'h07,
  parameter logic [7:0]  SEED     = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progReq,
  input  logic              reloadReq,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  output logic              hostWrAccept,
  output logic              rfRdEn,
  output logic [ADDR_W-1:0] rfRdAddr,
  input  logic [7:0]        rfRdData,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [7:0]        rfWrData,
  output logic              busy,
  output logic              nvCrcErr,
  output logic              thrCrcErr
);

  dpCtrl_t    ctrl;
  logic [7:0] crcQ;
  logic       mismatch;

  crcGuardControl #(
    .ADDR_W(ADDR_W), .NV_BASE(NV_BASE), .NV_LEN(NV_LEN),
    .THR_BASE(THR_BASE), .THR_LEN(THR_LEN), .SEED(SEED)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .progReq(progReq), .reloadReq(reloadReq),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .crcQ(crcQ), .mismatch(mismatch), .ctrl(ctrl),
    .rfRdEn(rfRdEn), .rfRdAddr(rfRdAddr), .rfWrEn(rfWrEn),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData), .hostWrAccept(hostWrAccept),
    .busy(busy), .nvErr(nvCrcErr), .thrErr(thrCrcErr)
  );

  crcGuardDatapath #(.POLY(POLY), .SEED(SEED)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rdData(rfRdData),
    .crcQ(crcQ), .mismatch(mismatch)
  );

endmodule

// File: tb/crcGuardTop_tb_top.sv
module crcGuardTop_tb_top;

  localparam int NV_BASE = 0, NV_LEN = 43, THR_BASE = 95, THR_LEN = 32;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progReq = 1'b0, reloadReq = 1'b0, hostWrEn = 1'b0;
  logic [6:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic       hostWrAccept, rfRdEn, rfWrEn, busy, nvCrcErr, thrCrcErr;
  logic [6:0] rfRdAddr, rfWrAddr;
  logic [7:0] rfRdData, rfWrData;

  logic [7:0] rfMem  [128];
  logic [7:0] refMem [128];

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  crcGuardTop dut_i (
    .clk(clk), .rstN(rstN), .progReq(progReq), .reloadReq(reloadReq),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostWrAccept(hostWrAccept), .rfRdEn(rfRdEn), .rfRdAddr(rfRdAddr),
    .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr),
    .rfWrData(rfWrData), .busy(busy), .nvCrcErr(nvCrcErr), .thrCrcErr(thrCrcErr)
  );

  // behavioural register file with synchronous read
  always @(posedge clk) begin
    if (rfRdEn) rfRdData <= rfMem[rfRdAddr];
    if (rfWrEn) rfMem[rfWrAddr] <= rfWrData;
  end

  // ---------------- reference model ----------------
  int         mAct = 0;     // 0 idle, 1 non-volatile, 2 threshold
  int         mLeft = 0;    // busy cycles still to go
  bit         mPendNv = 1, mPendChk = 1, mPendThr = 0, mChk = 0;
  logic [7:0] mCrc = '0, mStored = '0;
  logic       mNvErr = 0, mThrErr = 1;

  function automatic logic [7:0] refCrc(int base, int n);
    logic [7:0] c;
    c = 8'hFF;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[7] ^ refMem[base+i][b];
        c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  function automatic int winBase(int r);
    return (r == 2) ? THR_BASE : NV_BASE;
  endfunction
  function automatic int winLen(int r);
    return (r == 2) ? THR_LEN : NV_LEN;
  endfunction

  function automatic bit expAccept();
    int a;
    a = int'(hostAddr);
    if (!hostWrEn) return 0;
    if (mAct == 0) return 1;
    if (mLeft == 1) return 0;
    return !(a >= winBase(mAct) && a <= winBase(mAct) + winLen(mAct));
  endfunction

  task automatic startScan(int r);
    mAct  = r;
    mLeft = winLen(r) + 2;
    mChk  = (r == 1) ? mPendChk : 0;
    if (r == 1) mPendNv = 0; else mPendThr = 0;
    mCrc    = refCrc(winBase(r), winLen(r));
    mStored = refMem[winBase(r) + winLen(r)];
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 0; mLeft = 0; mPendNv = 1; mPendChk = 1; mPendThr = 0;
      mNvErr = 0; mThrErr = 1;
    end else begin
      bit acc, trig;
      acc  = expAccept();
      trig = acc && hostAddr >= 7'(THR_BASE) && hostAddr < 7'(THR_BASE + THR_LEN);
      if (acc) refMem[hostAddr] = hostWrData;
      if (mAct != 0) begin
        mLeft--;
        if (mLeft == 0) begin
          refMem[winBase(mAct) + winLen(mAct)] = mCrc;
          if (mAct == 1) mNvErr = mChk ? (mStored != mCrc) : 1'b0;
          else           mThrErr = 1'b0;
          mAct = 0;
        end
      end else if (mPendNv) startScan(1);
      else if (mPendThr)    startScan(2);
      if (progReq)   begin mPendNv = 1; mPendChk = 0; end
      if (reloadReq) begin mPendNv = 1; mPendChk = 1; end
      if (trig) mPendThr = 1;
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    #2;
    cycles++;
    if (cycles > WATCHDOG) begin
      check(0, "R4", "watchdog expired", cycles, WATCHDOG);
      finishRun();
    end
    check(busy === (mAct != 0), "R4", "busy", busy, mAct != 0);
    check(nvCrcErr === mNvErr, "R6 R10", "nvCrcErr", nvCrcErr, mNvErr);
    check(thrCrcErr === mThrErr, "R7 R10", "thrCrcErr", thrCrcErr, mThrErr);
    check(hostWrAccept === expAccept(), "R9", "hostWrAccept", hostWrAccept, expAccept());
    if (mAct != 0 && mLeft >= 2) begin
      int ea;
      ea = winBase(mAct) + winLen(mAct) + 2 - mLeft;
      check(rfRdEn === 1'b1, "R5 R8", "read enable", rfRdEn, 1);
      check(int'(rfRdAddr) == ea, "R5 R8", "read address", rfRdAddr, ea);
    end else begin
      check(rfRdEn === 1'b0, "R5", "read enable idle", rfRdEn, 0);
    end
    if (mAct != 0 && mLeft == 1) begin
      check(rfWrEn === 1'b1 && int'(rfWrAddr) == winBase(mAct) + winLen(mAct),
            "R2", "write-back address", rfWrAddr, winBase(mAct) + winLen(mAct));
      check(rfWrData === mCrc, "R1", "write-back value", rfWrData, mCrc);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit p, input bit r, input bit w, input int a, input int d);
    @(negedge clk);
    progReq = p; reloadReq = r; hostWrEn = w;
    hostAddr = 7'(a); hostWrData = 8'(d);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic waitIdle();
    quiet(2);
    while (mAct != 0 || mPendNv || mPendThr) quiet(1);
    quiet(1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      rfMem[i]  = 8'((i * 37 + 11) & 255);
      refMem[i] = rfMem[i];
    end
    // deliberately wrong stored value so the power-up reload flags an error
    refMem[NV_BASE + NV_LEN] = refCrc(NV_BASE, NV_LEN) ^ 8'h5A;
    rfMem[NV_BASE + NV_LEN]  = refMem[NV_BASE + NV_LEN];

    quiet(3);
    // R3: reset state
    check(busy === 1'b0 && nvCrcErr === 1'b0 && thrCrcErr === 1'b1, "R3",
          "reset state", {busy, nvCrcErr, thrCrcErr}, 3'b001);
    @(negedge clk); rstN = 1'b1;
    quiet(1);
    check(busy === 1'b1, "R3", "power-up reload started", busy, 1);
    waitIdle();
    check(nvCrcErr === 1'b1, "R6", "power-up mismatch flagged", nvCrcErr, 1);

    // R6: commit clears, reload of matching data stays clear
    cyc(1, 0, 0, 0, 0); waitIdle();
    cyc(0, 1, 0, 0, 0); waitIdle();
    check(nvCrcErr === 1'b0, "R6", "reload of matching data", nvCrcErr, 0);

    // R6: corrupt a non-volatile byte (no scan), then reload
    cyc(0, 0, 1, 16, 8'hAA); quiet(3);
    check(busy === 1'b0, "R7", "non-volatile write starts nothing", busy, 0);
    cyc(0, 1, 0, 0, 0); waitIdle();

    // R7 and R9: threshold write, then host traffic during the scan
    cyc(0, 0, 1, 96, 8'h33);
    for (int i = 0; i < 40; i++) begin
      int a;
      a = (i % 4 == 0) ? 101 : (i % 4 == 1) ? 5 : (i % 4 == 2) ? 127 : 112;
      cyc(0, 0, 1, a, i);
    end
    waitIdle();
    check(thrCrcErr === 1'b0, "R7", "threshold check clears flag", thrCrcErr, 0);

    // R7: check-byte write does not trigger
    cyc(0, 0, 1, 127, 8'h12); quiet(3);
    check(busy === 1'b0, "R7", "check-byte write starts nothing", busy, 0);

    // R8: simultaneous requests, requests while busy
    cyc(1, 0, 1, 97, 8'h44); quiet(5);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 98, 8'h55);
    cyc(0, 1, 0, 0, 0);
    waitIdle();

    // R8: commit and reload together, reload kind wins
    cyc(0, 0, 1, 32, 8'h01); quiet(1);
    cyc(1, 1, 0, 0, 0); waitIdle();
    check(nvCrcErr === 1'b1, "R8", "reload wins over commit", nvCrcErr, 1);

    // R9: host writes inside the scanned non-volatile window are refused
    cyc(0, 1, 0, 0, 0);
    for (int i = 0; i < 50; i++) cyc(0, 0, 1, (i % 2) ? 43 : 0, 8'hC0 + i);
    waitIdle();

    for (int i = 0; i < 128; i++)
      check(rfMem[i] === refMem[i], "R1 R2", "final register file", rfMem[i], refMem[i]);
    finishRun();
  end

endmodule